// File: doc/BRIEF.md
# EPROM Fast Programming Sequencer

This controller writes a range of bytes into a byte-wide one-time-programmable memory. It uses an adaptive pulse scheme. For each address it first reads the cell and refuses to touch it if the wanted data needs a 0 bit turned back into a 1. It then gives short program pulses, each one millisecond long, and reads the byte back after every pulse. When the read-back matches, it gives one trailing overprogram pulse. That pulse lasts three milliseconds for each short pulse the byte needed. A byte that still does not match after the pulse budget is reported as a failure.

When the whole range is programmed, the controller drops both supply selects to the nominal level and reads every byte again against its intended value. Time is measured only by counting a one-cycle millisecond strobe, so the host sets real pulse widths by how often it raises that strobe.

Intended data arrives on a valid/ready byte stream, one byte per address in ascending order, once for the programming pass and once again for the final check. The controller raises `src_ready` only while it waits for the next byte. A source that holds `src_valid` low simply stalls the sequence, and nothing is lost. Each byte is taken on a cycle where both `src_valid` and `src_ready` are high.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the block is idle: `ce_n` and `oe_n` are 1, `dev_drive`, `src_ready`, `vcc_hi`, `vpp_hi`, `done` and `fail` are 0.
- R2: `src_ready` is high only while the block waits for a byte. Exactly one byte is taken per address per pass, in ascending address order from `addr_lo` to `addr_hi`. A low `src_valid` stalls the sequence without loss.
- R3: A short pulse holds `ce_n`=0 and `oe_n`=1 while driving the wanted byte (`dev_drive`=1), and it lasts exactly one `ms_tick` period, from just after one strobe through the next.
- R4: After every short pulse the block reads back the byte: `ce_n`=0, `oe_n`=0, bus released (`dev_drive`=0), sampled after SETTLE settling cycles.
- R5: Short pulses repeat until the read-back matches, up to MAX_PULSES per byte. A byte that matches on the MAX_PULSES-th read-back still passes.
- R6: After a match, exactly one overprogram pulse of OVP_MULT·X tick periods is given, where X is that byte's short-pulse count (OVP_MULT=3).
- R7: If the byte still mismatches after MAX_PULSES short pulses, the block stops with `fail`=1, `fail_addr` = that address and `fail_code`=1, gives no overprogram pulse and leaves later addresses untouched.
- R8: If the wanted byte has a 1 where the cell already reads 0, the block stops with `fail_code`=2 and that address, and gives no pulse to it.
- R9: During the programming pass `vcc_hi`=`vpp_hi`=1. During the final pass both are 0 and no pulse is given.
- R10: A mismatch in the final pass stops the block with `fail_code`=3 and that address.
- R11: `done` rises only when both passes finish clean. `done` and `fail` never assert together and hold until the next `start`. `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| start | input | 1 | Begin a run (when not busy) |
| addr_lo | input | AW | First address of the range |
| addr_hi | input | AW | Last address of the range |
| src_valid | input | 1 | Intended byte is present |
| src_ready | output | 1 | Block accepts a byte this cycle |
| src_data | input | DW | Intended byte |
| dev_addr | output | AW | Memory address bus |
| dev_data_out | output | DW | Byte driven to the memory data pins |
| dev_drive | output | 1 | Data pins driven by the block |
| dev_data_in | input | DW | Byte read from the memory data pins |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| vcc_hi | output | 1 | Core supply at elevated setting |
| vpp_hi | output | 1 | Program supply at elevated setting |
| done | output | 1 | Both passes finished clean |
| fail | output | 1 | Run stopped on an error |
| fail_addr | output | AW | Address that failed |
| fail_code | output | 2 | 1 pulse budget spent, 2 cell unprogrammable, 3 final compare |

## Verification
A wrong short-pulse counter shows up first in the width of the trailing overprogram pulse, which is visible on `ce_n` one pulse after the matching read-back. It also shows up in how many pulses an address gets before a budget failure. A stale address or pass register shows up at the stream as an extra or missing byte taken. It also shows at the supply selects as an elevated level during the final pass, or a pulse there, within one address of the fault. Errors in the settle or tick counters change pulse widths or the read-back decision by whole cycles or tick periods, and the bench measures every `ce_n` pulse width to the cycle.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_PRE_RD, ST_ALIGN, ST_PULSE,
    ST_VFY_RD, ST_NEXT, ST_FIN_RD, ST_DONE, ST_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_EXHAUST = 2'd1,
    FC_BLOCKED = 2'd2,
    FC_FINAL   = 2'd3
  } fail_code_e;
endpackage

// File: rtl/eprom_tick_timer.sv
// Counts millisecond strobes; expire marks the strobe that ends the pulse.
module eprom_tick_timer #(
  parameter int LENW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LENW-1:0] len,
  input  logic            ms_tick,
  output logic            expire
);
  logic [LENW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= len;
    else if (ms_tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expire = ms_tick && (cnt == LENW'(1));
endmodule

// File: rtl/eprom_settle.sv
// Read settling delay: ready once SETTLE cycles have passed since load.
module eprom_settle #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int SW = $clog2(SETTLE + 2);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= SW'(SETTLE);
    else if (cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/eprom_byte_judge.sv
// Compares a read-back byte with the wanted byte.
module eprom_byte_judge #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] want,
  input  logic [DW-1:0] got,
  output logic          match,
  output logic          blocked
);
  assign match   = (want == got);
  // a wanted 1 over a cell already at 0 can never be reached
  assign blocked = |(want & ~got);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int MAX_PULSES = 25,
  parameter int OVP_MULT   = 3,
  parameter int SETTLE     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          start,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_data_out,
  output logic          dev_drive,
  input  logic [DW-1:0] dev_data_in,
  output logic          ce_n,
  output logic          oe_n,
  output logic          vcc_hi,
  output logic          vpp_hi,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_code
);
  localparam int XW   = $clog2(MAX_PULSES + 1);
  localparam int LENW = $clog2(OVP_MULT * MAX_PULSES + 1);

  seq_state_e      state, nxt;
  logic [AW-1:0]   cur, lo_q, hi_q;
  logic [DW-1:0]   want_q;
  logic [XW-1:0]   x_cnt;
  logic            pass2, ovp_phase;
  logic            reading, rd_enter, rd_ready, expire, match, blocked;
  logic [LENW-1:0] pulse_len;
  logic            budget_out, last_addr, busy;

  assign reading    = (state == ST_PRE_RD) || (state == ST_VFY_RD) || (state == ST_FIN_RD);
  assign rd_enter   = (nxt != state) &&
                      ((nxt == ST_PRE_RD) || (nxt == ST_VFY_RD) || (nxt == ST_FIN_RD));
  assign budget_out = (x_cnt == XW'(MAX_PULSES));
  assign last_addr  = (cur == hi_q);
  assign busy       = !((state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL));
  assign pulse_len  = ovp_phase ? LENW'(LENW'(OVP_MULT) * LENW'(x_cnt)) : LENW'(1);

  eprom_tick_timer #(.LENW(LENW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(state == ST_ALIGN && ms_tick),
    .len(pulse_len), .ms_tick(ms_tick), .expire(expire));

  eprom_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(rd_enter), .ready(rd_ready));

  eprom_byte_judge #(.DW(DW)) u_judge (
    .want(want_q), .got(dev_data_in), .match(match), .blocked(blocked));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE, ST_FAIL: if (start) nxt = ST_FETCH;
      ST_FETCH:  if (src_valid) nxt = pass2 ? ST_FIN_RD : ST_PRE_RD;
      ST_PRE_RD: if (rd_ready)  nxt = blocked ? ST_FAIL : ST_ALIGN;
      ST_ALIGN:  if (ms_tick)   nxt = ST_PULSE;
      ST_PULSE:  if (expire)    nxt = ovp_phase ? ST_NEXT : ST_VFY_RD;
      ST_VFY_RD: if (rd_ready)  nxt = (!match && budget_out) ? ST_FAIL : ST_ALIGN;
      ST_FIN_RD: if (rd_ready)  nxt = match ? ST_NEXT : ST_FAIL;
      ST_NEXT:   nxt = (last_addr && pass2) ? ST_DONE : ST_FETCH;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      want_q    <= '0;
      x_cnt     <= '0;
      pass2     <= 1'b0;
      ovp_phase <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_code <= FC_NONE;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE, ST_DONE, ST_FAIL: if (start) begin
          cur       <= addr_lo;
          lo_q      <= addr_lo;
          hi_q      <= addr_hi;
          pass2     <= 1'b0;
          done      <= 1'b0;
          fail      <= 1'b0;
          fail_addr <= '0;
          fail_code <= FC_NONE;
        end
        ST_FETCH: if (src_valid) begin
          want_q    <= src_data;
          x_cnt     <= '0;
          ovp_phase <= 1'b0;
        end
        ST_PRE_RD: if (rd_ready && blocked) begin
          fail      <= 1'b1;
          fail_addr <= cur;
          fail_code <= FC_BLOCKED;
        end
        ST_ALIGN: if (ms_tick && !ovp_phase) x_cnt <= x_cnt + 1'b1;
        ST_VFY_RD: if (rd_ready) begin
          if (match) ovp_phase <= 1'b1;
          else if (budget_out) begin
            fail      <= 1'b1;
            fail_addr <= cur;
            fail_code <= FC_EXHAUST;
          end
        end
        ST_FIN_RD: if (rd_ready && !match) begin
          fail      <= 1'b1;
          fail_addr <= cur;
          fail_code <= FC_FINAL;
        end
        ST_NEXT: begin
          if (!last_addr)  cur <= cur + 1'b1;
          else if (pass2)  done <= 1'b1;
          else begin
            pass2 <= 1'b1;
            cur   <= lo_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign src_ready    = (state == ST_FETCH);
  assign dev_addr     = cur;
  assign dev_data_out = want_q;
  assign dev_drive    = (state == ST_PULSE) || (state == ST_ALIGN);
  assign ce_n         = !((state == ST_PULSE) || reading);
  assign oe_n         = !reading;
  assign vcc_hi       = busy && !pass2;
  assign vpp_hi       = busy && !pass2;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int AW   = 8,
  parameter int MAXP = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          src_valid,
  input logic          src_ready,
  input logic          ce_n,
  input logic          oe_n,
  input logic          dev_drive,
  input logic          vcc_hi,
  input logic          vpp_hi,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_addr
);
  logic        pulse_now, pulse_prev;
  logic [15:0] pulses_here;

  assign pulse_now = !ce_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_prev  <= 1'b0;
      pulses_here <= '0;
    end else begin
      pulse_prev <= pulse_now;
      if (src_valid && src_ready)       pulses_here <= '0;
      else if (pulse_now && !pulse_prev) pulses_here <= pulses_here + 1'b1;
    end
  end

  p_pulse_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_now |-> (dev_drive && vpp_hi && vcc_hi));

  p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && !dev_drive));

  p_fetch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (ce_n && oe_n));

  p_pulse_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_here <= 16'(MAXP + 1));

  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_addr)));

  p_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> (ce_n && !vpp_hi && !vcc_hi));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.AW(AW), .MAXP(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_valid(src_valid),
  .src_ready(src_ready), .ce_n(ce_n), .oe_n(oe_n), .dev_drive(dev_drive),
  .vcc_hi(vcc_hi), .vpp_hi(vpp_hi), .done(done), .fail(fail),
  .fail_addr(fail_addr));

// File: tb/eprom_prog_seq_bench.sv
`timescale 1ns/1ps
module eprom_prog_seq_bench;
  localparam int TP = 20;

  logic       clk = 0, rst_n = 0, ms_tick = 0, start = 0;
  logic [7:0] addr_lo = 0, addr_hi = 0;
  logic       src_valid = 0, src_ready;
  logic [7:0] src_data = 0, dev_addr, dev_data_out, dev_data_in, fail_addr;
  logic       dev_drive, ce_n, oe_n, vcc_hi, vpp_hi, done, fail;
  logic [1:0] fail_code;

  eprom_prog_seq u_eprom_prog_seq (.*);

  always #5 clk = ~clk;

  int checks = 0, errs = 0;
  bit finished = 0;

  logic [7:0] mem [256];
  logic [7:0] want [256];
  int need [256], np [256], ovp [256];
  int run = 0, hs_cnt = 0, lowsup = 0, bad_rd = 0, bad_data = 0;
  logic [7:0] paddr = 0, pdata = 0, ptr = 0, weak_a = 0;
  bit weak_en = 0, stall = 0, hs = 0, src_en = 0;
  int tick_ctr = 0, cyc = 0;

  // memory model: reads only with ce_n/oe_n low and bus released
  assign dev_data_in = (!ce_n && !oe_n && !dev_drive) ?
    (mem[dev_addr] ^ ((weak_en && !vpp_hi && dev_addr == weak_a) ? 8'h01 : 8'h00)) : 8'hFF;

  always @(negedge clk) begin
    tick_ctr <= (tick_ctr == TP - 1) ? 0 : tick_ctr + 1;
    ms_tick  <= (tick_ctr == TP - 1);
    cyc      <= cyc + 1;
  end

  // byte source
  always @(posedge clk) hs <= src_valid && src_ready;
  always @(negedge clk) begin
    logic [7:0] p;
    p = ptr;
    if (hs) p = (ptr == addr_hi) ? addr_lo : ptr + 1;
    ptr       <= p;
    src_data  <= want[p];
    src_valid <= src_en && !(stall && (cyc % 3 == 0));
  end

  // pulse recorder and cell programming
  always @(posedge clk) begin
    if (src_valid && src_ready) hs_cnt <= hs_cnt + 1;
    if (!oe_n && dev_drive) bad_rd <= bad_rd + 1;
    if (!ce_n && oe_n) begin
      if (!vpp_hi) lowsup <= lowsup + 1;
      if (run == 0) begin paddr <= dev_addr; pdata <= dev_data_out; end
      run <= run + 1;
    end else if (run != 0) begin
      run <= 0;
      if (pdata != want[paddr]) bad_data <= bad_data + 1;
      if (run == TP) begin
        np[paddr] <= np[paddr] + 1;
        if (np[paddr] + 1 == need[paddr]) mem[paddr] <= mem[paddr] & pdata;
      end else ovp[paddr] <= run;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; want[i] = 8'h00; need[i] = 1; np[i] = 0; ovp[i] = 0;
    end
    hs_cnt = 0; lowsup = 0; bad_rd = 0; bad_data = 0; weak_en = 0; stall = 0;
  endtask

  task automatic run_seq(input logic [7:0] lo, input logic [7:0] hi, input int poke_at);
    int n;
    @(negedge clk);
    addr_lo = lo; addr_hi = hi; ptr = lo; src_data = want[lo]; src_en = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!(done || fail) && n < 40000) begin
      @(negedge clk);
      n++;
      if (n == poke_at) start = 1; else start = 0;
    end
    start = 0; src_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ce_n && oe_n, "R1 enables idle", {ce_n, oe_n}, 3);
    chk(!dev_drive && !src_ready && !vcc_hi && !vpp_hi, "R1 drive/ready/supplies",
        {dev_drive, src_ready, vcc_hi, vpp_hi}, 0);
    chk(!done && !fail, "R1 status", {done, fail}, 0);
  endtask

  task automatic t_clean();
    int nd [4] = '{1, 2, 4, 3};
    logic [7:0] wd [4] = '{8'h5A, 8'h00, 8'hA5, 8'h7E};
    clear_model();
    stall = 1;
    for (int i = 0; i < 4; i++) begin want[8'h10 + i] = wd[i]; need[8'h10 + i] = nd[i]; end
    run_seq(8'h10, 8'h13, 150);  // start raised mid-run must be ignored (R11)
    chk(done && !fail, "R11 done after clean run", {done, fail}, 2);
    chk(hs_cnt == 8, "R2 bytes taken (two passes)", hs_cnt, 8);
    for (int i = 0; i < 4; i++) begin
      chk(np[8'h10 + i] == nd[i], "R5 short pulses per byte", np[8'h10 + i], nd[i]);
      chk(ovp[8'h10 + i] == 3 * nd[i] * TP, "R6 overprogram width", ovp[8'h10 + i], 3 * nd[i] * TP);
      chk(mem[8'h10 + i] == wd[i], "R3 byte written", mem[8'h10 + i], wd[i]);
    end
    chk(bad_data == 0, "R3 pulse data", bad_data, 0);
    chk(bad_rd == 0, "R4 read with bus driven", bad_rd, 0);
    chk(lowsup == 0, "R9 no pulse at nominal supply", lowsup, 0);
    chk(np[8'h14] == 0 && np[8'h0F] == 0, "R2 range bounds", np[8'h14] + np[8'h0F], 0);
  endtask

  task automatic t_boundary();
    clear_model();
    want[8'h40] = 8'h81; need[8'h40] = 25;
    run_seq(8'h40, 8'h40, 0);
    chk(done && !fail, "R5 pass on last allowed pulse", {done, fail}, 2);
    chk(np[8'h40] == 25, "R5 pulse count at budget", np[8'h40], 25);
    chk(ovp[8'h40] == 75 * TP, "R6 overprogram at budget", ovp[8'h40], 75 * TP);
  endtask

  task automatic t_exhaust();
    clear_model();
    want[8'h20] = 8'h11; want[8'h21] = 8'h22; want[8'h22] = 8'h33;
    need[8'h21] = 26;
    run_seq(8'h20, 8'h22, 0);
    chk(fail && !done, "R7 fail raised", {fail, done}, 2);
    chk(fail_code == 2'd1, "R7 fail code", fail_code, 1);
    chk(fail_addr == 8'h21, "R7 fail address", fail_addr, 8'h21);
    chk(np[8'h21] == 25, "R7 pulses before giving up", np[8'h21], 25);
    chk(ovp[8'h21] == 0, "R7 no overprogram", ovp[8'h21], 0);
    chk(np[8'h22] == 0 && mem[8'h22] == 8'hFF, "R7 later address untouched", mem[8'h22], 8'hFF);
  endtask

  task automatic t_blocked();
    clear_model();
    want[8'h30] = 8'h0C; want[8'h31] = 8'hF0; mem[8'h31] = 8'h0F;
    run_seq(8'h30, 8'h31, 0);
    chk(fail && fail_code == 2'd2, "R8 fail code", fail_code, 2);
    chk(fail_addr == 8'h31, "R8 fail address", fail_addr, 8'h31);
    chk(np[8'h31] == 0 && ovp[8'h31] == 0, "R8 no pulse", np[8'h31], 0);
    chk(ovp[8'h30] == 3 * TP, "R8 earlier byte finished", ovp[8'h30], 3 * TP);
  endtask

  task automatic t_final();
    clear_model();
    for (int i = 0; i < 3; i++) begin want[8'h50 + i] = 8'h3C; need[8'h50 + i] = 2; end
    weak_en = 1; weak_a = 8'h51;
    run_seq(8'h50, 8'h52, 0);
    chk(fail && !done && fail_code == 2'd3, "R10 fail code", fail_code, 3);
    chk(fail_addr == 8'h51, "R10 fail address", fail_addr, 8'h51);
    chk(np[8'h52] == 2, "R9 program pass completed first", np[8'h52], 2);
    chk(lowsup == 0, "R9 final pass gave no pulse", lowsup, 0);
    chk(hs_cnt == 5, "R2 bytes taken up to final failure", hs_cnt, 5);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_boundary();
    t_exhaust();
    t_blocked();
    t_final();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end
endmodule